// File: doc/BRIEF.md
# PUF Soft-Response Filter, Ternary Quantizer and Bit Balancer

This block turns a run of multi-bit soft samples into a balanced string of hard bits. Each sample is the number of times one stable cell powered up as one over repeated start-ups. A run is loaded into an internal buffer. The block then makes three passes over that buffer. The first pass smooths the run with a centered moving average and gathers the sum and the sum of squares of the smoothed values. The second pass sorts each smoothed value into one, zero or indeterminate by its distance from the run mean, measured against the variance. The third pass evens out the count of ones and zeros and emits the surviving bits.

Indeterminate positions are dropped from the bit stream. A separate mask stream reports, in position order, which positions were dropped. When the ones and zeros differ by more than a limit, a 16-bit LFSR picks which majority bits to invert. A forced rule makes sure the required number of inversions is always reached within the single emit pass. When a run ends, the block reports the number of bits kept and the number inverted.

Top module: `puf_quant`

## Requirements
- R1: A sample is taken on each cycle in which `smp_valid_i` and `smp_ready_o` are both high. A run ends on a sample with `smp_last_i` high, or on the MAX_LEN-th sample if no last flag comes. `smp_ready_o` is 1 while a run is being loaded. It is 0 from the cycle after the final sample until processing of that run is finished.
- R2: The smoothed value at position i is floor(sum of s[j] for j from i-H to i+H, divided by WIN), where H = (WIN-1)/2 and WIN is 3, 5 or 7. A sample index outside 0..N-1 contributes zero.
- R3: Let N be the run length, S the sum and Q the sum of squares of the smoothed values, V = N*Q - S*S and d = N*x - S. A smoothed value x becomes 1 when d > 0 and 4*d*d > alpha*V. It becomes 0 when d < 0 and 4*d*d > beta*V. `alpha_q_i` and `beta_q_i` hold alpha and beta as unsigned integers in quarter units.
- R4: Every other value, including d = 0, is indeterminate and is not emitted as a bit. The mask stream gives one flag per position in position order, with 1 meaning indeterminate. `mask_last_o` marks position N-1.
- R5: With D = |ones - zeros| after quantization, exactly floor(D/2) bits of the majority value are inverted when D > `bal_limit_i`. Otherwise no bit is inverted. When the counts are equal, zero counts as the majority value.
- R6: Kept bits are scanned in position order. While inversions remain, each kept majority bit is a candidate. A candidate is inverted when LFSR bit 0 is 1, or when the candidates left (this one included) equal the inversions left. The LFSR steps once per candidate as l <= {l[14:0], l[15]^l[13]^l[12]^l[10]}. It is loaded from `seed_i` when the first sample of a run is taken.
- R7: The bit stream carries exactly the kept bits, after balancing, in position order. `bit_last_o` is high with the final kept bit only. A run with no kept bits emits nothing.
- R8: `done_o` pulses for one cycle at the end of each run. In that cycle `kept_cnt_o` and `flip_cnt_o` take the run's kept count and inversion count, and they hold those values until the next `done_o`.
- R9: After reset, `smp_ready_o` is 1. The mask, bit and done outputs are 0, and both counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_valid_i | input | 1 | Sample present |
| smp_data_i | input | SW | Soft sample |
| smp_last_i | input | 1 | Final sample of the run |
| smp_ready_o | output | 1 | Block accepts samples |
| alpha_q_i | input | 4 | Upper scale factor, quarter units |
| beta_q_i | input | 4 | Lower scale factor, quarter units |
| bal_limit_i | input | clog2(MAX_LEN+1) | Allowed ones/zeros difference |
| seed_i | input | 16 | LFSR seed |
| mask_valid_o | output | 1 | Mask flag present |
| mask_o | output | 1 | Position is indeterminate |
| mask_last_o | output | 1 | Flag for the final position |
| bit_valid_o | output | 1 | Output bit present |
| bit_o | output | 1 | Balanced bit |
| bit_last_o | output | 1 | Final kept bit |
| done_o | output | 1 | Run finished |
| kept_cnt_o | output | clog2(MAX_LEN+1) | Bits kept in the last run |
| flip_cnt_o | output | clog2(MAX_LEN+1) | Bits inverted in the last run |

## Verification
The assertions assume that `alpha_q_i`, `beta_q_i` and `bal_limit_i` stay constant from the first sample of a run until its `done_o`. They also assume that the sample stream never pushes past MAX_LEN. The stimulus sets the configuration before each run and changes it only after `done_o`. It relies on `smp_ready_o` alone to stop feeding, which also covers the run that ends without a last flag. The sample patterns are a single spike, a ramp, a hashed sequence, alternating blocks and a constant run. Together they make all three classes appear, reach the zero-padded edges and drive both balance directions, including the forced-inversion rule.

// File: rtl/puf_quant_pkg.sv
package puf_quant_pkg;

  typedef enum logic [2:0] {
    ST_LOAD,
    ST_FILT,
    ST_QUANT,
    ST_PREP,
    ST_BAL
  } pq_state_e;

  // x^16 + x^14 + x^13 + x^11 + 1, shift toward msb
  function automatic logic [15:0] lfsr_next(input logic [15:0] l);
    return {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
  endfunction

endpackage

// File: rtl/pq_win_mean.sv
module pq_win_mean #(
  parameter int SW      = 8,
  parameter int MAX_LEN = 64,
  parameter int WIN     = 3,
  localparam int LW     = $clog2(MAX_LEN + 1),
  localparam int AW     = $clog2(MAX_LEN)
) (
  input  logic [SW-1:0] buf_i [MAX_LEN],
  input  logic [LW-1:0] len_i,
  input  logic [LW-1:0] idx_i,
  output logic [SW-1:0] mean_o
);
  localparam int HALF  = (WIN - 1) / 2;
  localparam int SUM_W = SW + $clog2(WIN);
  localparam int SH    = SUM_W + 3;
  localparam int RECIP = ((1 << SH) + WIN - 1) / WIN;
  localparam int PW    = SUM_W + SH + 1;

  logic [SW-1:0] tap [WIN];

  for (genvar t = 0; t < WIN; t++) begin : g_tap
    localparam int OFF = t - HALF;
    logic signed [LW+1:0] pos;
    logic                 inr;
    assign pos = $signed({2'b00, idx_i}) + $signed((LW+2)'(OFF));
    assign inr = (pos >= 0) && (pos < $signed({2'b00, len_i}));
    assign tap[t] = inr ? buf_i[pos[AW-1:0]] : '0;
  end

  logic [SUM_W-1:0] sum;
  logic [PW-1:0]    prod;

  always_comb begin
    sum = '0;
    for (int k = 0; k < WIN; k++) sum = sum + SUM_W'(tap[k]);
  end

  // exact floor division by WIN via scaled reciprocal
  assign prod   = PW'(sum) * PW'(RECIP);
  assign mean_o = SW'(prod >> SH);

endmodule

// File: rtl/pq_classify.sv
module pq_classify #(
  parameter int SW = 8,
  parameter int LW = 7,
  localparam int S_W  = SW + LW,
  localparam int SQ_W = 2 * SW + LW,
  localparam int CW   = 2 * (SW + LW) + 8
) (
  input  logic [SW-1:0]   x_i,
  input  logic [LW-1:0]   n_i,
  input  logic [S_W-1:0]  s_i,
  input  logic [SQ_W-1:0] sq_i,
  input  logic [3:0]      alpha_i,
  input  logic [3:0]      beta_i,
  output logic            one_o,
  output logic            zero_o
);
  logic signed [CW-1:0] n_e, x_e, s_e, sq_e, a_e, b_e;
  logic signed [CW-1:0] d, v, lhs;

  assign n_e  = CW'(n_i);
  assign x_e  = CW'(x_i);
  assign s_e  = CW'(s_i);
  assign sq_e = CW'(sq_i);
  assign a_e  = CW'(alpha_i);
  assign b_e  = CW'(beta_i);

  // scaled by N^2: no division, no square root
  assign d   = n_e * x_e - s_e;
  assign v   = n_e * sq_e - s_e * s_e;
  assign lhs = (d * d) <<< 2;

  assign one_o  = (d > 0) && (lhs > a_e * v);
  assign zero_o = (d < 0) && (lhs > b_e * v);

endmodule

// File: rtl/pq_lfsr.sv
module pq_lfsr
  import puf_quant_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic [15:0] seed_i,
  input  logic        step_i,
  output logic [15:0] state_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_o <= 16'h0001;
    else if (load_i) state_o <= seed_i;
    else if (step_i) state_o <= lfsr_next(state_o);
  end

  AST_LFSR_NOT_STUCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && state_o != 16'h0) |=> (state_o != 16'h0)); // R6

endmodule

// File: rtl/puf_quant.sv
module puf_quant
  import puf_quant_pkg::*;
#(
  parameter int SW      = 8,
  parameter int MAX_LEN = 64,
  parameter int WIN     = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         smp_valid_i,
  input  logic [SW-1:0]                smp_data_i,
  input  logic                         smp_last_i,
  output logic                         smp_ready_o,
  input  logic [3:0]                   alpha_q_i,
  input  logic [3:0]                   beta_q_i,
  input  logic [$clog2(MAX_LEN+1)-1:0] bal_limit_i,
  input  logic [15:0]                  seed_i,
  output logic                         mask_valid_o,
  output logic                         mask_o,
  output logic                         mask_last_o,
  output logic                         bit_valid_o,
  output logic                         bit_o,
  output logic                         bit_last_o,
  output logic                         done_o,
  output logic [$clog2(MAX_LEN+1)-1:0] kept_cnt_o,
  output logic [$clog2(MAX_LEN+1)-1:0] flip_cnt_o
);
  localparam int LW   = $clog2(MAX_LEN + 1);
  localparam int AW   = $clog2(MAX_LEN);
  localparam int S_W  = SW + LW;
  localparam int SQ_W = 2 * SW + LW;

  pq_state_e state_q;
  logic [LW-1:0]   len_q, idx_q;
  logic [S_W-1:0]  s_q;
  logic [SQ_W-1:0] sq_q;
  logic [LW-1:0]   ones_q, zeros_q, kept_q, need_q, majcnt_q;
  logic [LW-1:0]   seen_q, left_q, flips_q, emit_q;
  logic            maj_q;

  logic [SW-1:0]      raw_q  [MAX_LEN];
  logic [SW-1:0]      filt_q [MAX_LEN];
  logic [MAX_LEN-1:0] qbit_q, qkeep_q;

  logic [AW-1:0] idx_a;
  logic          accept, last_idx;
  logic [SW-1:0] f_w;
  logic          c_one, c_zero;
  logic [15:0]   lfsr;
  logic          cand, flip;
  logic [LW-1:0] remain;

  assign idx_a       = idx_q[AW-1:0];
  assign smp_ready_o = (state_q == ST_LOAD);
  assign accept      = smp_valid_i && smp_ready_o;
  assign last_idx    = (idx_q == len_q - LW'(1));

  pq_win_mean #(.SW(SW), .MAX_LEN(MAX_LEN), .WIN(WIN)) u_win (
    .buf_i (raw_q),
    .len_i (len_q),
    .idx_i (idx_q),
    .mean_o(f_w)
  );

  pq_classify #(.SW(SW), .LW(LW)) u_cls (
    .x_i    (filt_q[idx_a]),
    .n_i    (len_q),
    .s_i    (s_q),
    .sq_i   (sq_q),
    .alpha_i(alpha_q_i),
    .beta_i (beta_q_i),
    .one_o  (c_one),
    .zero_o (c_zero)
  );

  // balance decision for the current position
  assign cand   = (state_q == ST_BAL) && qkeep_q[idx_a] && (qbit_q[idx_a] == maj_q) && (left_q != '0);
  assign remain = majcnt_q - seen_q;
  assign flip   = cand && (lfsr[0] || (remain == left_q));

  pq_lfsr u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept && (len_q == '0)),
    .seed_i (seed_i),
    .step_i (cand),
    .state_o(lfsr)
  );

  always_ff @(posedge clk_i) begin
    if (accept) raw_q[len_q[AW-1:0]] <= smp_data_i;
    if (state_q == ST_FILT) filt_q[idx_a] <= f_w;
    if (state_q == ST_QUANT) begin
      qbit_q[idx_a]  <= c_one;
      qkeep_q[idx_a] <= c_one || c_zero;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_LOAD;
      len_q        <= '0;
      idx_q        <= '0;
      s_q          <= '0;
      sq_q         <= '0;
      ones_q       <= '0;
      zeros_q      <= '0;
      kept_q       <= '0;
      need_q       <= '0;
      majcnt_q     <= '0;
      maj_q        <= 1'b0;
      seen_q       <= '0;
      left_q       <= '0;
      flips_q      <= '0;
      emit_q       <= '0;
      mask_valid_o <= 1'b0;
      mask_o       <= 1'b0;
      mask_last_o  <= 1'b0;
      bit_valid_o  <= 1'b0;
      bit_o        <= 1'b0;
      bit_last_o   <= 1'b0;
      done_o       <= 1'b0;
      kept_cnt_o   <= '0;
      flip_cnt_o   <= '0;
    end else begin
      mask_valid_o <= 1'b0;
      mask_last_o  <= 1'b0;
      bit_valid_o  <= 1'b0;
      bit_last_o   <= 1'b0;
      done_o       <= 1'b0;
      unique case (state_q)
        ST_LOAD: begin
          if (accept) begin
            len_q <= len_q + LW'(1);
            if (smp_last_i || (len_q == LW'(MAX_LEN - 1))) begin
              state_q <= ST_FILT;
              idx_q   <= '0;
              s_q     <= '0;
              sq_q    <= '0;
            end
          end
        end
        ST_FILT: begin
          s_q   <= s_q + S_W'(f_w);
          sq_q  <= sq_q + SQ_W'(f_w) * SQ_W'(f_w);
          idx_q <= idx_q + LW'(1);
          if (last_idx) begin
            state_q <= ST_QUANT;
            idx_q   <= '0;
            ones_q  <= '0;
            zeros_q <= '0;
          end
        end
        ST_QUANT: begin
          mask_valid_o <= 1'b1;
          mask_o       <= !(c_one || c_zero);
          mask_last_o  <= last_idx;
          ones_q       <= ones_q + LW'(c_one);
          zeros_q      <= zeros_q + LW'(c_zero);
          idx_q        <= idx_q + LW'(1);
          if (last_idx) state_q <= ST_PREP;
        end
        ST_PREP: begin
          logic [LW-1:0] diff;
          maj_q    <= ones_q > zeros_q;
          diff      = (ones_q > zeros_q) ? ones_q - zeros_q : zeros_q - ones_q;
          need_q   <= (diff > bal_limit_i) ? diff >> 1 : '0;
          left_q   <= (diff > bal_limit_i) ? diff >> 1 : '0;
          majcnt_q <= (ones_q > zeros_q) ? ones_q : zeros_q;
          kept_q   <= ones_q + zeros_q;
          idx_q    <= '0;
          seen_q   <= '0;
          flips_q  <= '0;
          emit_q   <= '0;
          state_q  <= ST_BAL;
        end
        ST_BAL: begin
          if (qkeep_q[idx_a]) begin
            bit_valid_o <= 1'b1;
            bit_o       <= qbit_q[idx_a] ^ flip;
            bit_last_o  <= (emit_q == kept_q - LW'(1));
            emit_q      <= emit_q + LW'(1);
          end
          seen_q  <= seen_q + LW'(cand);
          left_q  <= left_q - LW'(flip);
          flips_q <= flips_q + LW'(flip);
          idx_q   <= idx_q + LW'(1);
          if (last_idx) begin
            state_q    <= ST_LOAD;
            len_q      <= '0;
            done_o     <= 1'b1;
            kept_cnt_o <= kept_q;
            flip_cnt_o <= flips_q + LW'(flip);
          end
        end
        default: state_q <= ST_LOAD;
      endcase
    end
  end

  AST_NO_OVERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> (len_q < LW'(MAX_LEN))); // R1
  AST_NO_MASK_WHILE_LOADING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_ready_o |-> !mask_valid_o); // R1
  AST_MASK_LAST_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_last_o |-> mask_valid_o); // R4
  AST_FLIPS_MET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (flip_cnt_o == need_q)); // R5
  AST_BIT_LAST_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_last_o |-> bit_valid_o); // R7
  AST_EMIT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (emit_q == kept_cnt_o)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8

endmodule

// File: tb/puf_quant_tb_top.sv
module puf_quant_tb_top;
  localparam int SW  = 8;
  localparam int MAX = 64;
  localparam int W   = 3;
  localparam int LW  = $clog2(MAX + 1);

  typedef struct packed {
    logic [6:0]  len;
    logic [2:0]  pat;
    logic [7:0]  k;
    logic [3:0]  a;
    logic [3:0]  b;
    logic [6:0]  lim;
    logic [15:0] seed;
  } case_t;

  localparam int NC = 7;
  localparam case_t CASES [NC] = '{
    '{7'd16, 3'd0, 8'd7,  4'd4, 4'd0, 7'd16, 16'h1234},
    '{7'd16, 3'd0, 8'd7,  4'd4, 4'd0, 7'd2,  16'hBEEF},
    '{7'd40, 3'd1, 8'd6,  4'd1, 4'd1, 7'd0,  16'h0F0F},
    '{7'd64, 3'd2, 8'd0,  4'd0, 4'd0, 7'd0,  16'hACE1},
    '{7'd30, 3'd3, 8'd5,  4'd8, 4'd2, 7'd3,  16'h0000},
    '{7'd20, 3'd4, 8'd90, 4'd4, 4'd4, 7'd1,  16'h5555},
    '{7'd1,  3'd4, 8'd100,4'd0, 4'd0, 7'd0,  16'h0001}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          smp_valid = 1'b0, smp_last = 1'b0;
  logic [SW-1:0] smp_data = '0;
  logic [3:0]    alpha = '0, beta = '0;
  logic [LW-1:0] lim = '0;
  logic [15:0]   seed = '0;
  logic smp_ready, mask_valid, mask_bit, mask_last, bit_valid, bit_val, bit_last, done;
  logic [LW-1:0] kept_cnt, flip_cnt;

  puf_quant #(.SW(SW), .MAX_LEN(MAX), .WIN(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .smp_valid_i(smp_valid), .smp_data_i(smp_data), .smp_last_i(smp_last),
    .smp_ready_o(smp_ready),
    .alpha_q_i(alpha), .beta_q_i(beta), .bal_limit_i(lim), .seed_i(seed),
    .mask_valid_o(mask_valid), .mask_o(mask_bit), .mask_last_o(mask_last),
    .bit_valid_o(bit_valid), .bit_o(bit_val), .bit_last_o(bit_last),
    .done_o(done), .kept_cnt_o(kept_cnt), .flip_cnt_o(flip_cnt)
  );

  int n_chk = 0, n_fail = 0, cycles = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model state
  int smp [MAX];
  int ex_nbits, ex_flips, ex_kept;
  logic [63:0] ex_mask, ex_bits;

  function automatic int gen(input int pat, input int k, input int i);
    case (pat)
      0: return (i == k) ? 255 : 0;
      1: return (i * k) & 255;
      2: return ((i * 37 + k) ^ (i * i * 13)) & 255;
      3: return ((i / k) % 2) ? 200 : 20;
      default: return k;
    endcase
  endfunction

  function automatic logic [15:0] lstep(input logic [15:0] l);
    return {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
  endfunction

  task automatic model(input int n, input int a, input int b, input int lm, input logic [15:0] sd);
    longint f [MAX];
    longint s = 0, q = 0, v, d, lhs;
    int ones = 0, zeros = 0, diff, need, majcnt, seen = 0, left;
    logic maj;
    logic qb [MAX];
    logic qk [MAX];
    logic [15:0] l = sd;
    for (int i = 0; i < n; i++) begin
      longint acc = 0;
      for (int t = -(W - 1) / 2; t <= (W - 1) / 2; t++)
        if (i + t >= 0 && i + t < n) acc += smp[i + t];
      f[i] = acc / W;
      s += f[i];
      q += f[i] * f[i];
    end
    v = n * q - s * s;
    ex_mask = '0;
    for (int i = 0; i < n; i++) begin
      d = n * f[i] - s;
      lhs = 4 * d * d;
      qb[i] = (d > 0) && (lhs > a * v);
      qk[i] = qb[i] || ((d < 0) && (lhs > b * v));
      ex_mask[i] = !qk[i];
      if (qb[i]) ones++;
      else if (qk[i]) zeros++;
    end
    maj = ones > zeros;
    diff = maj ? ones - zeros : zeros - ones;
    need = (diff > lm) ? diff / 2 : 0;
    majcnt = maj ? ones : zeros;
    left = need;
    ex_flips = 0; ex_nbits = 0; ex_bits = '0; ex_kept = ones + zeros;
    for (int i = 0; i < n; i++) begin
      if (qk[i]) begin
        logic bb = qb[i];
        if (bb == maj && left > 0) begin
          if (l[0] || (majcnt - seen) == left) begin
            bb = !bb; left--; ex_flips++;
          end
          l = lstep(l);
          seen++;
        end
        ex_bits[ex_nbits] = bb;
        ex_nbits++;
      end
    end
  endtask

  // output monitor
  int gm, gb, gm_last, gb_last, g_kept, g_flips;
  logic g_done;
  logic [63:0] g_mask, g_bits;

  always @(negedge clk) begin
    if (mask_valid) begin
      if (gm < 64) g_mask[gm] = mask_bit;
      if (mask_last) gm_last = gm;
      gm++;
    end
    if (bit_valid) begin
      if (gb < 64) g_bits[gb] = bit_val;
      if (bit_last) gb_last = gb;
      gb++;
    end
    if (done) begin
      g_done = 1'b1; g_kept = int'(kept_cnt); g_flips = int'(flip_cnt);
    end
  end

  task automatic run(input case_t c, input bit no_last, input string tag);
    int n = no_last ? MAX : int'(c.len);
    int sent = 0;
    for (int i = 0; i < MAX; i++) smp[i] = gen(int'(c.pat), int'(c.k), i);
    model(n, int'(c.a), int'(c.b), int'(c.lim), c.seed);
    gm = 0; gb = 0; gm_last = -1; gb_last = -1; g_done = 1'b0;
    g_mask = '0; g_bits = '0; g_kept = -1; g_flips = -1;
    alpha = c.a; beta = c.b; lim = LW'(c.lim); seed = c.seed;
    while (sent < (no_last ? MAX + 6 : n)) begin
      @(negedge clk);
      if (!smp_ready) break;
      smp_valid = 1'b1;
      smp_data  = SW'(smp[sent % MAX]);
      smp_last  = !no_last && (sent == n - 1);
      sent++;
    end
    if (smp_ready) @(negedge clk);
    smp_valid = 1'b0; smp_last = 1'b0;
    chk({"R1 ready low after run end ", tag}, 64'(smp_ready), 64'd0);
    for (int t = 0; t < 2000 && !g_done; t++) @(negedge clk);
    chk({"R2 R3 R4 mask stream ", tag}, g_mask, ex_mask);
    chk({"R4 mask count/last ", tag}, 64'({gm, gm_last}), 64'({n, n - 1}));
    chk({"R5 R6 R7 bit stream ", tag}, g_bits, ex_bits);
    chk({"R7 bit count/last ", tag}, 64'({gb, gb_last}), 64'({ex_nbits, ex_nbits - 1}));
    chk({"R5 R8 kept/flips ", tag}, 64'({g_kept, g_flips}), 64'({ex_kept, ex_flips}));
    @(negedge clk);
    chk({"R1 R8 ready after done ", tag}, 64'({smp_ready, done}), 64'({1'b1, 1'b0}));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 ready/valids", 64'({smp_ready, mask_valid, bit_valid, done}), 64'(4'b1000));
    chk("R9 counts", 64'({kept_cnt, flip_cnt}), 64'd0);
    for (int ci = 0; ci < NC; ci++) begin
      string tg;
      tg = $sformatf("case%0d", ci);
      run(CASES[ci], 1'b0, tg);
    end
    // R1 forced end at MAX_LEN without a last flag
    run(CASES[3], 1'b1, "overflow");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule